// File: doc/BRIEF.md
# Bus-Mapped Multiply-Accumulate Unit

A 16x16 multiplier that sits on a word-wide register bus of a small microcontroller. Software picks the operation by choosing one of four addresses when it writes the first operand: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. Writing the second operand starts the operation. The 32-bit outcome is then read back as a low word and a high word. A third word, the extension word, holds the sign of the outcome or the carry out of the addition.

The register window is eight words long and starts at the parameter `BASE`, which must be aligned to 16 bytes. Address bit 0 is ignored, because only full-word accesses exist. A write to the low result word preloads both the accumulator and the result, so a running sum can start from any seed. Reads are combinational from the stored state. An operation started by a write shows up in reads from the next cycle on.

Top module: `mmio_mac`

## Requirements
- R1: After reset, operand 1, operand 2, result, accumulator and extension word all read zero, and the mode is unsigned multiply.
- R2: A write to BASE+0x0, +0x2, +0x4 or +0x6 stores operand 1 and selects a mode. The mode code is address bits 2:1: 0 unsigned multiply, 1 signed multiply, 2 unsigned accumulate, 3 signed accumulate. A read of any of these four addresses returns operand 1, and a read of BASE+0x8 returns operand 2.
- R3: A write to BASE+0x8 stores operand 2 and runs the selected operation, and reads show the outcome from the next cycle. In the two multiply modes the result becomes the product and the accumulator becomes zero. In signed modes both operands are sign-extended from 16 bits.
- R4: In the two accumulate modes the product is added to the accumulator modulo 2^32, and the result takes the new accumulator value.
- R5: BASE+0xA reads result bits 15:0, and BASE+0xC reads result bits 31:16.
- R6: BASE+0xE reads the extension word. It is 0x0000 after an unsigned multiply. It is 0xFFFF after a signed multiply or signed accumulate whose 32-bit outcome has bit 31 set, and 0x0000 otherwise. After an unsigned accumulate it is 0x0001 if the addition carried out of bit 31, and 0x0000 otherwise.
- R7: A write to BASE+0xA loads both the accumulator and the result with the written word. The word is zero-extended in unsigned modes and sign-extended in signed modes. The extension word becomes 0xFFFF only in a signed mode when bit 15 of the written word is set; otherwise it becomes 0x0000.
- R8: Writes to BASE+0xC, to BASE+0xE and outside the window change nothing. Reads outside the window, or with read enable low, return zero.
- R9: A new operand-1 write changes the mode but leaves the result, the accumulator and the extension word untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | DATA_W | Read data, zero when not selected |

## Verification
The multiply path is tried with all-ones operands, which tell unsigned from signed extension apart (0xFFFE0001 against 0x00000001). It is also tried with 0x8000 by 1, which exposes a missing sign fill in the high word and the extension word. Repeated unsigned accumulation of the largest product forces a carry out of bit 31, so the carry flag is seen separately from the sign. A signed accumulate that goes negative checks the sign-based extension. Preloads of 0x8000 under an unsigned mode and under a signed mode separate zero-extension from sign-extension. Writes to the read-only words, to outside addresses and to operand 1 alone must leave every readback unchanged.

// File: rtl/mac_pkg.sv
package mac_pkg;

   // bit 0: signed operands, bit 1: accumulate
   typedef enum logic [1:0] {
      MODE_UMUL = 2'b00,
      MODE_SMUL = 2'b01,
      MODE_UMAC = 2'b10,
      MODE_SMAC = 2'b11
   } mac_mode_e;

   localparam logic [2:0] IDX_OP2 = 3'd4;
   localparam logic [2:0] IDX_RLO = 3'd5;
   localparam logic [2:0] IDX_RHI = 3'd6;
   localparam logic [2:0] IDX_EXT = 3'd7;

   typedef struct packed {
      logic      op1_wr;
      logic      op2_wr;
      logic      rlo_wr;
      mac_mode_e mode_sel;
   } mac_wr_t;

endpackage

// File: rtl/mac_addr_dec.sv
module mac_addr_dec
   import mac_pkg::*;
#(
   parameter int              ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h0130
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              hit,
   output logic [2:0]        idx,
   output mac_wr_t           stb
);
   localparam int TAG_LSB = 4;

   always_comb begin
      hit          = (addr[ADDR_W-1:TAG_LSB] == BASE[ADDR_W-1:TAG_LSB]);
      idx          = addr[3:1];
      stb.op1_wr   = wr && hit && !idx[2];
      stb.op2_wr   = wr && hit && (idx == IDX_OP2);
      stb.rlo_wr   = wr && hit && (idx == IDX_RLO);
      stb.mode_sel = mac_mode_e'(idx[1:0]);
   end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int DATA_W = 16,
   parameter int IMPL   = 0,
   localparam int RES_W = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              sgn,
   output logic [RES_W-1:0]  prod
);
   generate
      if (IMPL == 0) begin : g_shared
         // one (DATA_W+1)-bit signed array serves both signednesses
         logic signed [DATA_W:0]   ea, eb;
         logic signed [RES_W+1:0]  full;
         always_comb begin
            ea   = $signed({sgn & op_a[DATA_W-1], op_a});
            eb   = $signed({sgn & op_b[DATA_W-1], op_b});
            full = ea * eb;
            prod = full[RES_W-1:0];
         end
      end else begin : g_dual
         logic [RES_W-1:0]        p_u;
         logic signed [RES_W-1:0] p_s;
         always_comb begin
            p_u  = {{DATA_W{1'b0}}, op_a} * {{DATA_W{1'b0}}, op_b};
            p_s  = $signed(op_a) * $signed(op_b);
            prod = sgn ? p_s : p_u;
         end
      end
   endgenerate
endmodule

// File: rtl/mac_core.sv
module mac_core
   import mac_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IMPL   = 0,
   localparam int RES_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mac_wr_t           stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] op1_q,
   output logic [DATA_W-1:0] op2_q,
   output mac_mode_e         mode_q,
   output logic [RES_W-1:0]  res_q,
   output logic [RES_W-1:0]  acc_q,
   output logic [DATA_W-1:0] ext_q
);
   logic [RES_W-1:0] prod;
   logic [RES_W:0]   sum;
   logic [RES_W-1:0] seed;
   logic             sgn;

   assign sgn = mode_q[0];

   // trigger uses the incoming operand 2 directly
   mac_mult #(.DATA_W(DATA_W), .IMPL(IMPL)) u_mult (
      .op_a (op1_q),
      .op_b (wdata),
      .sgn  (sgn),
      .prod (prod)
   );

   always_comb begin
      sum  = {1'b0, acc_q} + {1'b0, prod};
      seed = sgn ? {{DATA_W{wdata[DATA_W-1]}}, wdata}
                 : {{DATA_W{1'b0}}, wdata};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op1_q  <= '0;
         op2_q  <= '0;
         mode_q <= MODE_UMUL;
         res_q  <= '0;
         acc_q  <= '0;
         ext_q  <= '0;
      end else begin
         if (stb.op1_wr) begin
            op1_q  <= wdata;
            mode_q <= stb.mode_sel;
         end
         if (stb.op2_wr) begin
            op2_q <= wdata;
            if (!mode_q[1]) begin
               res_q <= prod;
               acc_q <= '0;
               ext_q <= sgn ? {DATA_W{prod[RES_W-1]}} : '0;
            end else begin
               res_q <= sum[RES_W-1:0];
               acc_q <= sum[RES_W-1:0];
               ext_q <= sgn ? {DATA_W{sum[RES_W-1]}}
                            : {{(DATA_W-1){1'b0}}, sum[RES_W]};
            end
         end
         if (stb.rlo_wr) begin
            res_q <= seed;
            acc_q <= seed;
            ext_q <= (sgn && wdata[DATA_W-1]) ? '1 : '0;
         end
      end
   end
endmodule

// File: rtl/mac_rd_mux.sv
module mac_rd_mux
   import mac_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int RES_W = 2 * DATA_W
) (
   input  logic              rd,
   input  logic              hit,
   input  logic [2:0]        idx,
   input  logic [DATA_W-1:0] op1_q,
   input  logic [DATA_W-1:0] op2_q,
   input  logic [RES_W-1:0]  res_q,
   input  logic [DATA_W-1:0] ext_q,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      if (rd && hit) begin
         case (idx)
            IDX_OP2: rdata = op2_q;
            IDX_RLO: rdata = res_q[DATA_W-1:0];
            IDX_RHI: rdata = res_q[RES_W-1:DATA_W];
            IDX_EXT: rdata = ext_q;
            default: rdata = op1_q;
         endcase
      end
   end
endmodule

// File: rtl/mmio_mac.sv
module mmio_mac
   import mac_pkg::*;
#(
   parameter int                ADDR_W = 16,
   parameter int                DATA_W = 16,
   parameter logic [ADDR_W-1:0] BASE   = 16'h0130,
   parameter int                IMPL   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam int RES_W = 2 * DATA_W;

   generate
      if (ADDR_W < 5) begin : g_bad_aw
         $error("mmio_mac: ADDR_W must be at least 5");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("mmio_mac: DATA_W must be at least 2");
      end
      if (BASE[3:0] != 4'h0) begin : g_bad_base
         $error("mmio_mac: BASE must be 16-byte aligned");
      end
      if (IMPL != 0 && IMPL != 1) begin : g_bad_impl
         $error("mmio_mac: IMPL must be 0 or 1");
      end
   endgenerate

   logic              hit;
   logic [2:0]        idx;
   mac_wr_t           stb;
   logic [DATA_W-1:0] op1_w, op2_w, ext_w;
   logic [RES_W-1:0]  res_w, acc_w;
   mac_mode_e         mode_w;

   mac_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .addr (bus_addr),
      .wr   (bus_wr),
      .hit  (hit),
      .idx  (idx),
      .stb  (stb)
   );

   mac_core #(.DATA_W(DATA_W), .IMPL(IMPL)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (stb),
      .wdata  (bus_wdata),
      .op1_q  (op1_w),
      .op2_q  (op2_w),
      .mode_q (mode_w),
      .res_q  (res_w),
      .acc_q  (acc_w),
      .ext_q  (ext_w)
   );

   mac_rd_mux #(.DATA_W(DATA_W)) u_rd (
      .rd    (bus_rd),
      .hit   (hit),
      .idx   (idx),
      .op1_q (op1_w),
      .op2_q (op2_w),
      .res_q (res_w),
      .ext_q (ext_w),
      .rdata (bus_rdata)
   );
endmodule

// File: rtl/mmio_mac_chk.sv
module mmio_mac_chk #(
   parameter int                ADDR_W = 16,
   parameter int                DATA_W = 16,
   parameter logic [ADDR_W-1:0] BASE   = 16'h0130,
   localparam int               RES_W  = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [1:0]        mode_w,
   input logic [RES_W-1:0]  res_w,
   input logic [RES_W-1:0]  acc_w,
   input logic [DATA_W-1:0] ext_w
);
   logic in_win, trig, op1w, rowr;
   assign in_win = (bus_addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
   assign trig   = bus_wr && in_win && (bus_addr[3:1] == 3'd4);
   assign op1w   = bus_wr && in_win && !bus_addr[3];
   assign rowr   = bus_wr && (!in_win || bus_addr[3:1] == 3'd6 || bus_addr[3:1] == 3'd7);

   p_rd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> bus_rdata == '0);

   p_mul_clears_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && !mode_w[1]) |=> acc_w == '0);

   p_mac_result_is_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_w[1]) |=> res_w == acc_w);

   p_ext_umul_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_w == 2'b00) |=> ext_w == '0);

   p_ext_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (trig && mode_w[0]) |=> ext_w == {DATA_W{res_w[RES_W-1]}});

   p_ro_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rowr |=> ($stable(res_w) && $stable(acc_w) && $stable(ext_w)));

   p_mode_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op1w |=> mode_w == $past(bus_addr[2:1]));

   p_mode_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op1w |=> ($stable(res_w) && $stable(acc_w) && $stable(ext_w)));
endmodule

bind mmio_mac mmio_mac_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .mode_w    (mode_w),
   .res_w     (res_w),
   .acc_w     (acc_w),
   .ext_w     (ext_w)
);

// File: tb/mmio_mac_bench.sv
`timescale 1ns/1ps
module mmio_mac_bench;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 16;
   localparam logic [15:0] BASE = 16'h0130;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mmio_mac #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_mmio_mac (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

   // reference state
   logic [15:0] m_op1, m_op2, m_ext;
   logic [31:0] m_res, m_acc;
   int          m_mode;

   task automatic m_reset();
      m_op1 = 0; m_op2 = 0; m_ext = 0; m_res = 0; m_acc = 0; m_mode = 0;
   endtask

   task automatic m_write(input logic [15:0] a, input logic [15:0] d);
      longint ia, ib, p, s;
      bit sg;
      if (a[15:4] != BASE[15:4]) return;
      sg = (m_mode % 2) == 1;
      case (a[3:1])
         3'd0, 3'd1, 3'd2, 3'd3: begin m_op1 = d; m_mode = int'(a[2:1]); end
         3'd4: begin
            m_op2 = d;
            ia = sg ? longint'($signed(m_op1)) : longint'(m_op1);
            ib = sg ? longint'($signed(d))     : longint'(d);
            p  = (ia * ib) & 64'hFFFF_FFFF;
            if (m_mode < 2) begin
               m_res = p[31:0]; m_acc = 0;
               m_ext = (sg && p[31]) ? 16'hFFFF : 16'h0000;
            end else begin
               s = longint'(m_acc) + p;
               m_acc = s[31:0]; m_res = s[31:0];
               if (sg) m_ext = s[31] ? 16'hFFFF : 16'h0000;
               else    m_ext = s[32] ? 16'h0001 : 16'h0000;
            end
         end
         3'd5: begin
            m_res = sg ? {{16{d[15]}}, d} : {16'h0000, d};
            m_acc = m_res;
            m_ext = (sg && d[15]) ? 16'hFFFF : 16'h0000;
         end
         default: ;
      endcase
   endtask

   function automatic logic [15:0] m_read(input logic [15:0] a);
      if (a[15:4] != BASE[15:4]) return 16'h0000;
      case (a[3:1])
         3'd4: return m_op2;
         3'd5: return m_res[15:0];
         3'd6: return m_res[31:16];
         3'd7: return m_ext;
         default: return m_op1;
      endcase
   endfunction

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_rd = 0; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      m_write(a, d);
   endtask

   task automatic chk_read(input logic [15:0] a, input string tag);
      logic [15:0] exp;
      @(negedge clk);
      bus_wr = 0; bus_rd = 1; bus_addr = a;
      #1;
      exp = m_read(a);
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
      end
   endtask

   // compares every word of the window, one per clock
   task automatic chk_all(input string tag);
      for (int i = 0; i < 8; i++) chk_read(BASE + 16'(2 * i), tag);
   endtask

   task automatic chk_val(input logic [15:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      bus_wr = 0; bus_rd = 1; bus_addr = a;
      #1;
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      chk_all("R1 reset");

      // R2 operand readback and mode latch
      bus_write(BASE + 16'h0, 16'hFFFF);
      chk_all("R2 op1 umul");
      chk_val(BASE + 16'h6, 16'hFFFF, "R2 op1 alias");
      // R3/R5/R6 unsigned multiply
      bus_write(BASE + 16'h8, 16'hFFFF);
      chk_val(BASE + 16'hA, 16'h0001, "R5 umul lo");
      chk_val(BASE + 16'hC, 16'hFFFE, "R5 umul hi");
      chk_val(BASE + 16'hE, 16'h0000, "R6 umul ext");
      chk_all("R3 umul");
      // signed multiply of all-ones
      bus_write(BASE + 16'h2, 16'hFFFF);
      chk_all("R9 mode change keeps result");
      bus_write(BASE + 16'h8, 16'hFFFF);
      chk_val(BASE + 16'hC, 16'h0000, "R3 smul -1*-1 hi");
      chk_all("R3 smul");
      bus_write(BASE + 16'h2, 16'h8000);
      bus_write(BASE + 16'h8, 16'h0001);
      chk_val(BASE + 16'hC, 16'hFFFF, "R3 smul neg hi");
      chk_val(BASE + 16'hE, 16'hFFFF, "R6 smul ext");
      chk_all("R3 smul neg");

      // unsigned accumulate to carry
      bus_write(BASE + 16'h0, 16'h0000);
      bus_write(BASE + 16'h8, 16'h0000);
      bus_write(BASE + 16'h4, 16'hFFFF);
      bus_write(BASE + 16'h8, 16'hFFFF);
      chk_all("R4 umac 1");
      bus_write(BASE + 16'h8, 16'hFFFF);
      chk_val(BASE + 16'hC, 16'hFFFC, "R4 umac wrap hi");
      chk_val(BASE + 16'hE, 16'h0001, "R6 umac carry");
      chk_all("R4 umac 2");
      bus_write(BASE + 16'h8, 16'h0001);
      chk_val(BASE + 16'hE, 16'h0000, "R6 umac no carry");
      chk_all("R4 umac 3");

      // signed accumulate going negative
      bus_write(BASE + 16'h6, 16'h0003);
      bus_write(BASE + 16'hA, 16'h0002);
      chk_all("R7 smac preload");
      bus_write(BASE + 16'h8, 16'hFFFE);
      chk_val(BASE + 16'hE, 16'hFFFF, "R6 smac neg ext");
      chk_val(BASE + 16'hA, 16'hFFFC, "R4 smac lo");
      chk_all("R4 smac");
      bus_write(BASE + 16'h8, 16'h0002);
      chk_val(BASE + 16'hE, 16'h0000, "R6 smac pos ext");
      chk_all("R4 smac 2");

      // preload extension
      bus_write(BASE + 16'hA, 16'h8000);
      chk_val(BASE + 16'hC, 16'hFFFF, "R7 signed preload hi");
      chk_all("R7 signed preload");
      bus_write(BASE + 16'h4, 16'h0001);
      bus_write(BASE + 16'hA, 16'h8000);
      chk_val(BASE + 16'hC, 16'h0000, "R7 unsigned preload hi");
      chk_val(BASE + 16'hE, 16'h0000, "R7 unsigned preload ext");
      bus_write(BASE + 16'h8, 16'h0010);
      chk_val(BASE + 16'hA, 16'h8010, "R7 preload seeds acc");
      chk_all("R7 after accumulate");

      // ignored writes and idle reads
      bus_write(BASE + 16'hC, 16'h1234);
      bus_write(BASE + 16'hE, 16'h5678);
      bus_write(16'h0140, 16'h9ABC);
      bus_write(16'h0120, 16'h9ABC);
      chk_all("R8 ignored writes");
      chk_val(16'h0140, 16'h0000, "R8 outside read");
      chk_val(BASE + 16'hB, 16'h8010, "R8 odd address");
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; bus_addr = BASE + 16'hA;
      #1;
      checks++;
      if (bus_rdata !== 16'h0000) begin
         errors++;
         $display("FAIL R8 idle read actual=%h expected=0000", bus_rdata);
      end

      // reset again clears everything
      @(negedge clk) rst_n = 0;
      @(posedge clk);
      m_reset();
      @(negedge clk) rst_n = 1;
      chk_all("R1 reset again");
      bus_write(BASE + 16'h8, 16'h0007);
      chk_val(BASE + 16'hE, 16'h0000, "R1 reset mode umul");
      chk_all("R1 default mode");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule